// File: doc/BRIEF.md
# Decoded bytecode line fill unit

This block sits beside the decode stage of a stack-machine core. As bytecodes retire along the normal decode path, it collects them into one line, and each line covers a single basic block. It writes finished lines into a small direct-mapped cache of decoded lines. Each stored line is tagged by the fetch address of its first instruction. It carries the per-slot instruction lengths, so a consumer finds instruction boundaries without decoding again. It also carries a fall-through address and, for a line that ends in a conditional branch, the taken target.

The fetch side presents an address on the lookup port. In the same cycle the block reports whether a line is held for that address and returns the whole line. On a hit, the fetch logic takes the line in place of the instruction cache and decoder output. A flush input drops every stored line and any line still being built.

Top module: `dbc_fill_unit`

## Requirements
- R1: After reset every lookup misses. A lookup hits in the same cycle exactly when the entry indexed by the low 6 address bits is valid and its tag equals the remaining address bits. A line written by a retire is visible on the lookup port from the cycle after that retire's clock edge.
- R2: A line holds at most 5 instructions. Plain instructions (kind 2'b00) never stop filling. The fifth instruction closes the line, with next address equal to its address plus its length.
- R3: A group is written to the cache only when it holds two or more instructions. A group of one instruction is discarded, so its start address misses.
- R4: A retired instruction longer than 3 bytes is not stored. It closes the current group, which is written if it holds two or more instructions, with next address equal to the long instruction's address. The following instruction starts a new group.
- R5: A conditional branch (kind 2'b01) ends the line. The line's condition flag is set, its target field holds the branch target, and its next address is the branch address plus its length (the not-taken path).
- R6: Any other control transfer (kind 2'b10 or 2'b11) ends the line with the condition flag clear, target field zero, and next address equal to the transfer's target.
- R7: Slot k occupies payload bits [24k+23:24k] and length bits [2k+1:2k], and each length is written as a byte count from 1 to 3. Slots beyond the line's count read as zero.
- R8: The cache is direct-mapped. A new line overwrites the entry at its index, so the older line with the same index and a different tag then misses.
- R9: A flush clears all stored lines and drops the group under construction. Every lookup misses in the cycle after the flush, and an instruction retired after the flush starts a fresh group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines and the group in progress |
| ret_valid_i | input | 1 | A decoded instruction retires this cycle |
| ret_pc_i | input | 16 | Address of the retiring instruction |
| ret_len_i | input | 3 | Length of the retiring instruction in bytes |
| ret_kind_i | input | 2 | 00 plain, 01 conditional branch, 10/11 other control transfer |
| ret_bytes_i | input | 24 | Instruction bytes, opcode in bits [7:0] |
| ret_target_i | input | 16 | Target address for control transfers |
| lk_addr_i | input | 16 | Fetch address to look up |
| lk_hit_o | output | 1 | A line for lk_addr_i is held |
| lk_count_o | output | 3 | Instructions in the hit line |
| lk_lens_o | output | 10 | Per-slot lengths, 2 bits each |
| lk_bytes_o | output | 120 | Per-slot instruction bytes, 24 bits each |
| lk_next_o | output | 16 | Fall-through / not-taken address |
| lk_cond_o | output | 1 | Line ends in a conditional branch |
| lk_target_o | output | 16 | Taken target of the ending branch |

## Verification
Lookup is combinational, so the bench sets the lookup address, waits one time unit and samples the outputs. A line commits on the clock edge of the retire that closes it. The bench drives each retire after a falling edge, lets one rising edge pass, and reads the lookup port only after the following falling edge, at which point the write has landed. A flush has the same one-edge latency, and the misses it causes are checked after the next falling edge, before any further retire.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'b00,
    K_COND  = 2'b01,
    K_JUMP  = 2'b10,
    K_OTHER = 2'b11
  } ret_kind_e;
endpackage

// File: rtl/dbc_line_builder.sv
module dbc_line_builder
  import dbc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MAX_OPS  = 5,
  parameter int SLOT_B   = 3,
  parameter int LEN_IN_W = 3,
  parameter int CNT_W    = $clog2(MAX_OPS + 1),
  parameter int LEN_W    = $clog2(SLOT_B + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        ret_valid_i,
  input  logic [ADDR_W-1:0]           ret_pc_i,
  input  logic [LEN_IN_W-1:0]         ret_len_i,
  input  logic [1:0]                  ret_kind_i,
  input  logic [SLOT_B*8-1:0]         ret_bytes_i,
  input  logic [ADDR_W-1:0]           ret_target_i,
  output logic                        wr_en_o,
  output logic [ADDR_W-1:0]           wr_pc_o,
  output logic [CNT_W-1:0]            wr_count_o,
  output logic [MAX_OPS*LEN_W-1:0]    wr_lens_o,
  output logic [MAX_OPS*SLOT_B*8-1:0] wr_bytes_o,
  output logic [ADDR_W-1:0]           wr_next_o,
  output logic                        wr_cond_o,
  output logic [ADDR_W-1:0]           wr_target_o
);
  localparam int SLOT_W = SLOT_B * 8;
  localparam int LENS_W = MAX_OPS * LEN_W;
  localparam int PAY_W  = MAX_OPS * SLOT_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [ADDR_W-1:0] start_q, start_d, base_start, fall_pc;
  logic [LENS_W-1:0] lens_q, lens_d, base_lens, app_lens;
  logic [PAY_W-1:0]  bytes_q, bytes_d, base_bytes, app_bytes;
  logic              is_long, is_ctl, line_end;

  always_comb begin
    is_long    = ret_len_i > LEN_IN_W'(SLOT_B);
    is_ctl     = ret_kind_i != K_PLAIN;
    cnt_inc    = cnt_q + CNT_W'(1);
    line_end   = is_ctl || (cnt_inc == CNT_W'(MAX_OPS));
    fall_pc    = ret_pc_i + ADDR_W'(ret_len_i);
    // first slot of a group starts from a clean line
    base_start = (cnt_q == '0) ? ret_pc_i : start_q;
    base_lens  = (cnt_q == '0) ? '0 : lens_q;
    base_bytes = (cnt_q == '0) ? '0 : bytes_q;
    app_lens   = base_lens;
    app_bytes  = base_bytes;
    for (int k = 0; k < MAX_OPS; k++) begin
      if (cnt_q == CNT_W'(k)) begin
        app_lens[k*LEN_W +: LEN_W]   = ret_len_i[LEN_W-1:0];
        app_bytes[k*SLOT_W +: SLOT_W] = ret_bytes_i;
      end
    end
  end

  always_comb begin
    wr_en_o     = 1'b0;
    wr_pc_o     = start_q;
    wr_count_o  = cnt_q;
    wr_lens_o   = lens_q;
    wr_bytes_o  = bytes_q;
    wr_next_o   = ret_pc_i;
    wr_cond_o   = 1'b0;
    wr_target_o = '0;
    cnt_d       = cnt_q;
    start_d     = start_q;
    lens_d      = lens_q;
    bytes_d     = bytes_q;
    if (flush_i) begin
      cnt_d = '0;
    end else if (ret_valid_i) begin
      if (is_long) begin
        wr_en_o = cnt_q >= CNT_W'(2);
        cnt_d   = '0;
      end else if (line_end) begin
        wr_en_o     = cnt_inc >= CNT_W'(2);
        wr_pc_o     = base_start;
        wr_count_o  = cnt_inc;
        wr_lens_o   = app_lens;
        wr_bytes_o  = app_bytes;
        wr_cond_o   = ret_kind_i == K_COND;
        wr_next_o   = ret_kind_i[1] ? ret_target_i : fall_pc;
        wr_target_o = (ret_kind_i == K_COND) ? ret_target_i : '0;
        cnt_d       = '0;
      end else begin
        cnt_d   = cnt_inc;
        start_d = base_start;
        lens_d  = app_lens;
        bytes_d = app_bytes;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= '0;
      lens_q  <= '0;
      bytes_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
      lens_q  <= lens_d;
      bytes_q <= bytes_d;
    end
  end

  a_r2_open_below_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_OPS));
  a_r4_long_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !flush_i && is_long) |=> (cnt_q == '0));
  a_r3_commit_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_count_o >= CNT_W'(2)));
  a_r9_flush_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !wr_en_o);
endmodule

// File: rtl/dbc_line_store.sv
module dbc_line_store #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 64,
  parameter int MAX_OPS = 5,
  parameter int SLOT_B  = 3,
  parameter int CNT_W   = $clog2(MAX_OPS + 1),
  parameter int LEN_W   = $clog2(SLOT_B + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_pc_i,
  input  logic [CNT_W-1:0]            wr_count_i,
  input  logic [MAX_OPS*LEN_W-1:0]    wr_lens_i,
  input  logic [MAX_OPS*SLOT_B*8-1:0] wr_bytes_i,
  input  logic [ADDR_W-1:0]           wr_next_i,
  input  logic                        wr_cond_i,
  input  logic [ADDR_W-1:0]           wr_target_i,
  input  logic [ADDR_W-1:0]           lk_addr_i,
  output logic                        lk_hit_o,
  output logic [CNT_W-1:0]            lk_count_o,
  output logic [MAX_OPS*LEN_W-1:0]    lk_lens_o,
  output logic [MAX_OPS*SLOT_B*8-1:0] lk_bytes_o,
  output logic [ADDR_W-1:0]           lk_next_o,
  output logic                        lk_cond_o,
  output logic [ADDR_W-1:0]           lk_target_o
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LENS_W = MAX_OPS * LEN_W;
  localparam int PAY_W  = MAX_OPS * SLOT_B * 8;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [CNT_W-1:0]   cnt_q   [ENTRIES];
  logic [LENS_W-1:0]  lens_q  [ENTRIES];
  logic [PAY_W-1:0]   bytes_q [ENTRIES];
  logic [ADDR_W-1:0]  next_q  [ENTRIES];
  logic               cond_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q   [ENTRIES];

  logic [IDX_W-1:0] wr_idx, lk_idx;
  logic [TAG_W-1:0] wr_tag, lk_tag;

  assign wr_idx = wr_pc_i[IDX_W-1:0];
  assign wr_tag = wr_pc_i[ADDR_W-1:IDX_W];
  assign lk_idx = lk_addr_i[IDX_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !flush_i) begin
      tag_q[wr_idx]   <= wr_tag;
      cnt_q[wr_idx]   <= wr_count_i;
      lens_q[wr_idx]  <= wr_lens_i;
      bytes_q[wr_idx] <= wr_bytes_i;
      next_q[wr_idx]  <= wr_next_i;
      cond_q[wr_idx]  <= wr_cond_i;
      tgt_q[wr_idx]   <= wr_target_i;
    end
  end

  always_comb begin
    lk_hit_o    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    lk_count_o  = lk_hit_o ? cnt_q[lk_idx]   : '0;
    lk_lens_o   = lk_hit_o ? lens_q[lk_idx]  : '0;
    lk_bytes_o  = lk_hit_o ? bytes_q[lk_idx] : '0;
    lk_next_o   = lk_hit_o ? next_q[lk_idx]  : '0;
    lk_cond_o   = lk_hit_o && cond_q[lk_idx];
    lk_target_o = lk_hit_o ? tgt_q[lk_idx]   : '0;
  end

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> !lk_hit_o);
  a_r1_hit_count_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_count_o >= CNT_W'(2) && lk_count_o <= CNT_W'(MAX_OPS)));
  a_r8_fill_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i) |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/dbc_fill_unit.sv
module dbc_fill_unit #(
  parameter int ADDR_W   = 16,
  parameter int ENTRIES  = 64,
  parameter int MAX_OPS  = 5,
  parameter int SLOT_B   = 3,
  parameter int LEN_IN_W = 3,
  parameter int CNT_W    = $clog2(MAX_OPS + 1),
  parameter int LEN_W    = $clog2(SLOT_B + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        ret_valid_i,
  input  logic [ADDR_W-1:0]           ret_pc_i,
  input  logic [LEN_IN_W-1:0]         ret_len_i,
  input  logic [1:0]                  ret_kind_i,
  input  logic [SLOT_B*8-1:0]         ret_bytes_i,
  input  logic [ADDR_W-1:0]           ret_target_i,
  input  logic [ADDR_W-1:0]           lk_addr_i,
  output logic                        lk_hit_o,
  output logic [CNT_W-1:0]            lk_count_o,
  output logic [MAX_OPS*LEN_W-1:0]    lk_lens_o,
  output logic [MAX_OPS*SLOT_B*8-1:0] lk_bytes_o,
  output logic [ADDR_W-1:0]           lk_next_o,
  output logic                        lk_cond_o,
  output logic [ADDR_W-1:0]           lk_target_o
);
  logic                        wr_en;
  logic [ADDR_W-1:0]           wr_pc, wr_next, wr_target;
  logic [CNT_W-1:0]            wr_count;
  logic [MAX_OPS*LEN_W-1:0]    wr_lens;
  logic [MAX_OPS*SLOT_B*8-1:0] wr_bytes;
  logic                        wr_cond;

  dbc_line_builder #(
    .ADDR_W(ADDR_W), .MAX_OPS(MAX_OPS), .SLOT_B(SLOT_B),
    .LEN_IN_W(LEN_IN_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_build (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .ret_valid_i(ret_valid_i), .ret_pc_i(ret_pc_i), .ret_len_i(ret_len_i),
    .ret_kind_i(ret_kind_i), .ret_bytes_i(ret_bytes_i), .ret_target_i(ret_target_i),
    .wr_en_o(wr_en), .wr_pc_o(wr_pc), .wr_count_o(wr_count), .wr_lens_o(wr_lens),
    .wr_bytes_o(wr_bytes), .wr_next_o(wr_next), .wr_cond_o(wr_cond),
    .wr_target_o(wr_target)
  );

  dbc_line_store #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .MAX_OPS(MAX_OPS), .SLOT_B(SLOT_B),
    .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .wr_en_i(wr_en), .wr_pc_i(wr_pc), .wr_count_i(wr_count), .wr_lens_i(wr_lens),
    .wr_bytes_i(wr_bytes), .wr_next_i(wr_next), .wr_cond_i(wr_cond),
    .wr_target_i(wr_target), .lk_addr_i(lk_addr_i),
    .lk_hit_o(lk_hit_o), .lk_count_o(lk_count_o), .lk_lens_o(lk_lens_o),
    .lk_bytes_o(lk_bytes_o), .lk_next_o(lk_next_o), .lk_cond_o(lk_cond_o),
    .lk_target_o(lk_target_o)
  );
endmodule

// File: tb/sim_dbc_fill_unit.sv
`timescale 1ns/1ps
module sim_dbc_fill_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         rv = 1'b0;
  logic [15:0]  rpc = '0;
  logic [2:0]   rlen = '0;
  logic [1:0]   rkind = '0;
  logic [23:0]  rbytes = '0;
  logic [15:0]  rtgt = '0;
  logic [15:0]  la = '0;
  logic         hit;
  logic [2:0]   cnt;
  logic [9:0]   lens;
  logic [119:0] bytes;
  logic [15:0]  nxt, tgt;
  logic         cnd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dbc_fill_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .ret_valid_i(rv),
    .ret_pc_i(rpc), .ret_len_i(rlen), .ret_kind_i(rkind), .ret_bytes_i(rbytes),
    .ret_target_i(rtgt), .lk_addr_i(la), .lk_hit_o(hit), .lk_count_o(cnt),
    .lk_lens_o(lens), .lk_bytes_o(bytes), .lk_next_o(nxt), .lk_cond_o(cnd),
    .lk_target_o(tgt)
  );

  task automatic chk(input string req, input logic [119:0] act, input logic [119:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic retire(input logic [15:0] pc, input logic [2:0] len,
                        input logic [1:0] kind, input logic [23:0] b,
                        input logic [15:0] t);
    rv = 1'b1; rpc = pc; rlen = len; rkind = kind; rbytes = b; rtgt = t;
    @(posedge clk);
    @(negedge clk);
    rv = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    la = a;
    #1;
  endtask

  task automatic expect_line(input string req, input logic [15:0] a, input logic [2:0] c,
                             input logic [15:0] n, input logic cd, input logic [15:0] t);
    look(a);
    chk({req, " hit"}, 120'(hit), 120'(1'b1));
    chk({req, " count"}, 120'(cnt), 120'(c));
    chk({req, " next"}, 120'(nxt), 120'(n));
    chk({req, " cond"}, 120'(cnd), 120'(cd));
    chk({req, " target"}, 120'(tgt), 120'(t));
  endtask

  task automatic expect_miss(input string req, input logic [15:0] a);
    look(a);
    chk({req, " miss"}, 120'(hit), 120'(1'b0));
  endtask

  task automatic t_reset;
    expect_miss("R1 reset", 16'h0040);
    expect_miss("R1 reset", 16'h1010);
  endtask

  task automatic t_cond_line;
    retire(16'h1010, 3'd1, 2'b00, 24'h0000A1, 16'h0);
    retire(16'h1011, 3'd2, 2'b00, 24'h0012B2, 16'h0);
    retire(16'h1013, 3'd3, 2'b01, 24'h3456C3, 16'h0200);
    expect_line("R5", 16'h1010, 3'd3, 16'h1016, 1'b1, 16'h0200);
    chk("R7 payload", bytes, {48'h0, 24'h3456C3, 24'h0012B2, 24'h0000A1});
    chk("R7 lens", 120'(lens), 120'(10'b00_00_11_10_01));
    expect_miss("R1 tag mismatch", 16'h2010);
  endtask

  task automatic t_full_and_jump;
    for (int i = 0; i < 5; i++)
      retire(16'h2020 + 16'(i), 3'd1, 2'b00, 24'(i + 1), 16'h0);
    expect_line("R2", 16'h2020, 3'd5, 16'h2025, 1'b0, 16'h0);
    chk("R2 payload", bytes, {24'h5, 24'h4, 24'h3, 24'h2, 24'h1});
    retire(16'h2025, 3'd1, 2'b00, 24'h11, 16'h0);
    retire(16'h2026, 3'd2, 2'b10, 24'h22, 16'h2800);
    expect_line("R6", 16'h2025, 3'd2, 16'h2800, 1'b0, 16'h0);
  endtask

  task automatic t_single;
    retire(16'h3030, 3'd1, 2'b01, 24'h77, 16'h3300);
    expect_miss("R3 single", 16'h3030);
    retire(16'h3031, 3'd1, 2'b00, 24'h78, 16'h0);
    retire(16'h3032, 3'd1, 2'b11, 24'h79, 16'h3500);
    expect_line("R3 after single", 16'h3031, 3'd2, 16'h3500, 1'b0, 16'h0);
  endtask

  task automatic t_long;
    retire(16'h4038, 3'd1, 2'b00, 24'h01, 16'h0);
    retire(16'h4039, 3'd2, 2'b00, 24'h02, 16'h0);
    retire(16'h403B, 3'd5, 2'b00, 24'h03, 16'h0);
    expect_line("R4 closed", 16'h4038, 3'd2, 16'h403B, 1'b0, 16'h0);
    chk("R4 not stored", bytes, {72'h0, 24'h02, 24'h01});
    expect_miss("R4 long", 16'h403B);
    retire(16'h4040, 3'd1, 2'b00, 24'h04, 16'h0);
    retire(16'h4041, 3'd1, 2'b01, 24'h05, 16'h4100);
    expect_line("R4 restart", 16'h4040, 3'd2, 16'h4042, 1'b1, 16'h4100);
  endtask

  task automatic t_alias;
    retire(16'h5010, 3'd1, 2'b00, 24'h51, 16'h0);
    retire(16'h5011, 3'd1, 2'b01, 24'h52, 16'h5100);
    expect_line("R8 new", 16'h5010, 3'd2, 16'h5012, 1'b1, 16'h5100);
    expect_miss("R8 evicted", 16'h1010);
  endtask

  task automatic t_flush;
    retire(16'h6000, 3'd1, 2'b00, 24'h61, 16'h0);
    flush = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    expect_miss("R9 flushed", 16'h2020);
    expect_miss("R9 flushed", 16'h5010);
    expect_miss("R9 flushed", 16'h4040);
    retire(16'h6001, 3'd1, 2'b01, 24'h62, 16'h6100);
    expect_miss("R9 partial dropped", 16'h6000);
    expect_miss("R9 partial dropped", 16'h6001);
    retire(16'h7000, 3'd1, 2'b00, 24'h71, 16'h0);
    retire(16'h7001, 3'd2, 2'b00, 24'h72, 16'h0);
    retire(16'h7003, 3'd3, 2'b10, 24'h73, 16'h7800);
    expect_line("R9 refill", 16'h7000, 3'd3, 16'h7800, 1'b0, 16'h0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cond_line();
    t_full_and_jump();
    t_single();
    t_long();
    t_alias();
    t_flush();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule